// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns one data word per request into an asynchronous serial frame on a single output line. A frame is a low start bit, then 5 to 9 data bits least significant first, then an optional parity bit, then one or two high stop bits. Between frames the line rests high.

The frame format is chosen at run time from three encoded control inputs: a character-size code, a parity code and a stop-count select. Some codes are reserved. A reserved code falls back to a safe setting and raises a flag. The format and the data word are captured in the cycle a request is accepted, and they stay fixed until that frame ends.

Bit timing comes from an external baud tick, which pulses once per bit period. The block makes no baud rate of its own. A request uses a valid/ready handshake, and one frame is in flight at a time.

Top module: `uart_frame_tx`

## Requirements
- R1: While `rst` is high, and whenever `busy` is low, `txd` is 1. During reset `busy` is 0 and `in_ready` is 0. After reset is released, `in_ready` is 1 and `cfg_err` is 0.
- R2: A word is accepted on a rising clock edge where `in_valid` and `in_ready` are both 1. From the next cycle, `busy` is 1 and `in_ready` is 0 until the frame ends.
- R3: After acceptance `txd` stays 1 until the first `baud_tick`. Each later `baud_tick` moves the line to the next frame bit, and `txd` never changes without a tick. With B frame bits, tick B+1 returns the line to 1, clears `busy` and sets `in_ready`.
- R4: The first frame bit is a 0 start bit. It is followed by the low N bits of `in_data`, least significant bit first. Bits of `in_data` at position N and above are never sent.
- R5: `char_code` sets N: 3'b000 gives 5, 3'b001 gives 6, 3'b010 gives 7, 3'b011 gives 8, and 3'b111 gives 9.
- R6: `par_mode` 2'b00 sends no parity bit. 2'b10 sends an even-parity bit after the last data bit, so the data bits plus the parity bit hold an even number of ones. 2'b11 sends an odd-parity bit, so that count is odd.
- R7: `two_stop` 0 ends the frame with one stop bit of value 1. `two_stop` 1 ends it with two stop bits of value 1.
- R8: A reserved `char_code` (3'b100, 3'b101, 3'b110) sends 8 data bits. Reserved `par_mode` 2'b01 sends no parity bit. `cfg_err` becomes 1 in the cycle after a word is accepted with any reserved code, and 0 after a word is accepted with defined codes. It holds its value until the next acceptance.
- R9: Changes on `in_data`, `char_code`, `par_mode` and `two_stop` after acceptance do not alter the frame in flight. `in_valid` while `busy` is 1 starts no frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| baud_tick | input | 1 | One-cycle pulse per bit period |
| in_data | input | 9 | Data word; the low N bits are sent |
| in_valid | input | 1 | Request to send `in_data` |
| in_ready | output | 1 | Block can accept a word |
| par_mode | input | 2 | Parity code |
| two_stop | input | 1 | Stop count select: 0 for one, 1 for two |
| char_code | input | 3 | Character-size code |
| txd | output | 1 | Serial line |
| busy | output | 1 | Frame in progress |
| cfg_err | output | 1 | Last accepted word used a reserved code |

## Verification
The hardest case to show from the ports is that a frame already in flight ignores its inputs. A correct frame alone proves little, because the inputs may not have changed while it was sent. To reach this case, the bench accepts a word and then, in the very next cycle, changes the data word, the size code, the parity code and the stop select. It also holds `in_valid` high through most of the frame. It then compares every bit against the frame built from the original settings, and confirms that no second frame starts. A reset applied part way through a frame covers the other hard-to-reach state.

// File: rtl/txfr_pkg.sv
package txfr_pkg;
    localparam int DATA_W    = 9;
    localparam int FRAME_MAX = 1 + DATA_W + 1 + 2;
    localparam int LEN_W     = $clog2(FRAME_MAX + 1);
    localparam int NB_W      = $clog2(DATA_W + 1);
    localparam int SAFE_BITS = 8;

    typedef enum logic [1:0] {
        PAR_NONE = 2'b00,
        PAR_RSVD = 2'b01,
        PAR_EVEN = 2'b10,
        PAR_ODD  = 2'b11
    } par_code_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARMED,
        ST_SEND
    } tx_state_e;

    typedef struct packed {
        logic [NB_W-1:0] nbits;
        logic            par_en;
        logic            par_odd;
        logic            two_stop;
        logic            bad_code;
    } fmt_t;

    function automatic logic [NB_W-1:0] code_bits(input logic [2:0] c);
        case (c)
            3'b000:  return NB_W'(5);
            3'b001:  return NB_W'(6);
            3'b010:  return NB_W'(7);
            3'b011:  return NB_W'(8);
            3'b111:  return NB_W'(9);
            default: return NB_W'(SAFE_BITS);
        endcase
    endfunction

    function automatic logic code_reserved(input logic [2:0] c);
        return (c == 3'b100) || (c == 3'b101) || (c == 3'b110);
    endfunction
endpackage

// File: rtl/tx_fmt_decode.sv
module tx_fmt_decode
    import txfr_pkg::*;
(
    input  logic [2:0] char_code,
    input  logic [1:0] par_mode,
    input  logic       two_stop,
    output fmt_t       fmt
);
    par_code_e pc;

    always_comb begin
        pc           = par_code_e'(par_mode);
        fmt.nbits    = code_bits(char_code);
        fmt.par_en   = (pc == PAR_EVEN) || (pc == PAR_ODD);
        fmt.par_odd  = (pc == PAR_ODD);
        fmt.two_stop = two_stop;
        fmt.bad_code = code_reserved(char_code) || (pc == PAR_RSVD);
    end
endmodule

// File: rtl/tx_frame_build.sv
module tx_frame_build
    import txfr_pkg::*;
(
    input  fmt_t                  fmt,
    input  logic [DATA_W-1:0]     data,
    output logic [FRAME_MAX-1:0]  frame,
    output logic [LEN_W-1:0]      len
);
    logic [DATA_W-1:0] mask;
    logic              par_bit;

    always_comb begin
        mask = '0;
        for (int i = 0; i < DATA_W; i++) begin
            if (NB_W'(i) < fmt.nbits) mask[i] = 1'b1;
        end
        par_bit = (^(data & mask)) ^ fmt.par_odd;

        frame    = '1;
        frame[0] = 1'b0;
        for (int i = 0; i < DATA_W; i++) begin
            if (mask[i]) frame[i+1] = data[i];
        end
        if (fmt.par_en) frame[int'(fmt.nbits) + 1] = par_bit;

        len = LEN_W'(2) + LEN_W'(fmt.nbits)
            + LEN_W'(fmt.par_en) + LEN_W'(fmt.two_stop);
    end
endmodule

// File: rtl/tx_serializer.sv
module tx_serializer
    import txfr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick,
    input  logic                 load,
    input  logic [FRAME_MAX-1:0] frame,
    input  logic [LEN_W-1:0]     len,
    output logic                 line,
    output logic                 active
);
    tx_state_e            state;
    logic [FRAME_MAX-1:0] shreg;
    logic [LEN_W-1:0]     left;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            line  <= 1'b1;
            shreg <= '1;
            left  <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (load) begin
                        shreg <= frame;
                        left  <= len - LEN_W'(1);
                        state <= ST_ARMED;
                    end
                end
                ST_ARMED: begin
                    if (tick) begin
                        line  <= shreg[0];
                        shreg <= {1'b1, shreg[FRAME_MAX-1:1]};
                        state <= ST_SEND;
                    end
                end
                ST_SEND: begin
                    if (tick) begin
                        if (left == '0) begin
                            line  <= 1'b1;
                            state <= ST_IDLE;
                        end else begin
                            line  <= shreg[0];
                            shreg <= {1'b1, shreg[FRAME_MAX-1:1]};
                            left  <= left - LEN_W'(1);
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign active = (state != ST_IDLE);
endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
    import txfr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              baud_tick,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [1:0]        par_mode,
    input  logic              two_stop,
    input  logic [2:0]        char_code,
    output logic              txd,
    output logic              busy,
    output logic              cfg_err
);
    fmt_t                 fmt;
    logic [FRAME_MAX-1:0] frame;
    logic [LEN_W-1:0]     len;
    logic                 accept;

    assign in_ready = !rst && !busy;
    assign accept   = in_valid && in_ready;

    tx_fmt_decode u_dec (
        .char_code (char_code),
        .par_mode  (par_mode),
        .two_stop  (two_stop),
        .fmt       (fmt)
    );

    tx_frame_build u_build (
        .fmt   (fmt),
        .data  (in_data),
        .frame (frame),
        .len   (len)
    );

    tx_serializer u_ser (
        .clk    (clk),
        .rst    (rst),
        .tick   (baud_tick),
        .load   (accept),
        .frame  (frame),
        .len    (len),
        .line   (txd),
        .active (busy)
    );

    always_ff @(posedge clk) begin
        if (rst)         cfg_err <= 1'b0;
        else if (accept) cfg_err <= fmt.bad_code;
    end
endmodule

// File: rtl/tx_checker.sv
module tx_checker (
    input logic clk,
    input logic rst,
    input logic baud_tick,
    input logic in_valid,
    input logic in_ready,
    input logic txd,
    input logic busy,
    input logic cfg_err
);
    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
        !busy |-> txd); // R1
    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> (busy && !in_ready)); // R2
    AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (rst)
        (busy && !baud_tick) |=> $stable(txd)); // R3
    AST_ARM_LINE_HIGH: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> txd); // R3
    AST_END_STOP_HIGH: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (txd && in_ready)); // R7
    AST_ERR_HELD: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(cfg_err)); // R8
endmodule

bind uart_frame_tx tx_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .baud_tick (baud_tick),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .txd       (txd),
    .busy      (busy),
    .cfg_err   (cfg_err)
);

// File: tb/uart_frame_tx_bench.sv
module uart_frame_tx_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       baud_tick = 1'b0;
    logic [8:0] in_data = '0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [1:0] par_mode = 2'b00;
    logic       two_stop = 1'b0;
    logic [2:0] char_code = 3'b011;
    logic       txd, busy, cfg_err;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    uart_frame_tx u_uart_frame_tx (
        .clk(clk), .rst(rst), .baud_tick(baud_tick), .in_data(in_data),
        .in_valid(in_valid), .in_ready(in_ready), .par_mode(par_mode),
        .two_stop(two_stop), .char_code(char_code), .txd(txd),
        .busy(busy), .cfg_err(cfg_err)
    );

    typedef struct packed {
        logic [8:0] d;
        logic [1:0] pm;
        logic       ts;
        logic [2:0] cc;
        logic [3:0] len;
        logic       err;
    } vec_t;

    localparam logic [19:0] VECS [9] = '{
        {9'h0A5, 2'b00, 1'b0, 3'b011, 4'd10, 1'b0},
        {9'h1F3, 2'b10, 1'b0, 3'b000, 4'd8,  1'b0},
        {9'h03C, 2'b11, 1'b1, 3'b001, 4'd10, 1'b0},
        {9'h155, 2'b10, 1'b1, 3'b010, 4'd11, 1'b0},
        {9'h1A6, 2'b11, 1'b0, 3'b111, 4'd12, 1'b0},
        {9'h0F0, 2'b01, 1'b0, 3'b011, 4'd10, 1'b1},
        {9'h1C3, 2'b00, 1'b1, 3'b101, 4'd11, 1'b1},
        {9'h100, 2'b10, 1'b1, 3'b111, 4'd13, 1'b0},
        {9'h000, 2'b11, 1'b0, 3'b000, 4'd8,  1'b0}
    };

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic void ref_frame(input logic [8:0] d, input logic [1:0] pm,
                                      input logic ts, input logic [2:0] cc,
                                      output logic [12:0] bits, output int len);
        int  n;
        logic p;
        case (cc)
            3'b000: n = 5; 3'b001: n = 6; 3'b010: n = 7;
            3'b111: n = 9; default: n = 8;
        endcase
        bits = '1;
        bits[0] = 1'b0;
        p = (pm == 2'b11);
        for (int i = 0; i < n; i++) begin
            bits[i+1] = d[i];
            p = p ^ d[i];
        end
        len = 1 + n;
        if (pm[1]) begin
            bits[len] = p;
            len++;
        end
        len = len + (ts ? 2 : 1);
    endfunction

    task automatic tick();
        @(negedge clk) baud_tick = 1'b1;
        @(negedge clk) baud_tick = 1'b0;
    endtask

    task automatic accept(input logic [8:0] d, input logic [1:0] pm,
                          input logic ts, input logic [2:0] cc);
        @(negedge clk);
        in_data = d; par_mode = pm; two_stop = ts; char_code = cc;
        in_valid = 1'b1;
        @(negedge clk) in_valid = 1'b0;
    endtask

    task automatic run_frame(input logic [12:0] bits, input int len, input bit drop_valid);
        check("R3 line high before first tick", txd, 1);
        check("R2 busy after accept", busy, 1);
        check("R2 ready low after accept", in_ready, 0);
        for (int k = 0; k < len; k++) begin
            tick();
            if (drop_valid && k == len - 1) in_valid = 1'b0;
            if (k == 0)        check("R4 start bit", txd, 0);
            else               check("R5 R6 R7 frame bit", txd, bits[k]);
            check("R3 busy mid frame", busy, 1);
        end
        tick();
        check("R7 line high after last stop", txd, 1);
        check("R3 busy cleared at tick B+1", busy, 0);
        check("R2 ready back", in_ready, 1);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [12:0] bits;
        int          len;
        vec_t        v;

        repeat (3) @(negedge clk);
        check("R1 reset txd", txd, 1);
        check("R1 reset busy", busy, 0);
        check("R1 reset ready", in_ready, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 ready after reset", in_ready, 1);
        check("R1 cfg_err after reset", cfg_err, 0);
        check("R1 idle txd", txd, 1);

        // table walk: R4 R5 R6 R7 R8
        for (int i = 0; i < 9; i++) begin
            v = vec_t'(VECS[i]);
            ref_frame(v.d, v.pm, v.ts, v.cc, bits, len);
            check("R5 R6 R7 frame length", len, int'(v.len));
            accept(v.d, v.pm, v.ts, v.cc);
            check("R8 cfg_err", cfg_err, int'(v.err));
            run_frame(bits, len, 1'b0);
            check("R8 cfg_err held after frame", cfg_err, int'(v.err));
        end

        // R9: inputs change and valid held during frame
        ref_frame(9'h0A5, 2'b00, 1'b0, 3'b011, bits, len);
        accept(9'h0A5, 2'b00, 1'b0, 3'b011);
        in_data = 9'h15A; par_mode = 2'b11; two_stop = 1'b1; char_code = 3'b000;
        in_valid = 1'b1;
        run_frame(bits, len, 1'b1);
        repeat (3) @(negedge clk);
        check("R9 no frame from valid while busy", busy, 0);
        check("R9 line idle", txd, 1);
        check("R9 cfg_err unchanged by mid-frame codes", cfg_err, 0);

        // R4: upper bits beyond N never sent (5-bit, no parity, 1 stop)
        ref_frame(9'h1E0, 2'b00, 1'b0, 3'b000, bits, len);
        check("R4 reference masks upper bits", int'(bits[6:1]), 6'h20);
        accept(9'h1E0, 2'b00, 1'b0, 3'b000);
        run_frame(bits, len, 1'b0);

        // R1: reset during a frame
        accept(9'h0FF, 2'b01, 1'b1, 3'b110);
        check("R8 cfg_err reserved both", cfg_err, 1);
        tick(); tick();
        @(negedge clk) rst = 1'b1;
        @(negedge clk);
        check("R1 reset mid-frame txd", txd, 1);
        check("R1 reset mid-frame busy", busy, 0);
        check("R1 reset mid-frame ready", in_ready, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 cfg_err cleared by reset", cfg_err, 0);
        check("R1 ready after reset", in_ready, 1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule